// File: doc/BRIEF.md
# Oversampled 8N1 Serial Receiver with Framing-Error Handling

This block receives asynchronous serial bytes in the 8-data-bit, no-parity, one-stop-bit format on an idle-high line. A programmable divider turns the system clock into an oversampling tick, and each bit period lasts eight ticks. The divider input is therefore set to the system clock frequency divided by eight times the baud rate. The line passes through a two-flop synchronizer. A low level seen on a tick is taken as a start bit. The data bits are then sampled near their centres and the stop bit is checked.

A frame with a high stop bit puts its byte into an 8-entry receive queue. The receiver goes back to hunting for a start bit at once, with no added delay, so a transmitter that runs slightly fast is still tolerated. A low stop bit covers both framing errors and breaks. In that case the byte is discarded, a sticky frame-error flag is set, and the receiver waits for the line to go high before it hunts again.

The queue is read through a valid/ready port. `rd_valid` stays high while the queue holds data, and `rd_data` shows the oldest byte. That byte is removed in a cycle where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, the byte and the valid signal hold. `rd_ready` may be raised at any time; it has no effect while the queue is empty.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, `rd_valid` is 0, `rx_empty` is 1, and `frame_err` and `overrun` are 0.
- R2: The oversampling tick occurs once every `baud_div` clock cycles, where a value of 0 counts as 1. A bit period is 8 ticks, so frames sent at 8·`baud_div` clocks per bit are received correctly for any divider value.
- R3: With the line idle, a low level on the synchronized input seen on a tick starts a frame. The first data bit is sampled 12 ticks later, and each following data bit is sampled 8 ticks after the previous one.
- R4: Data bits arrive least significant bit first. They are shifted into the top of a 32-bit right-shifting register, so the finished byte is that register's most significant byte. That byte is what `rd_data` presents, with the first received bit at `rd_data[0]`.
- R5: The stop bit is sampled 8 ticks after the last data bit. If it is high, the byte is queued and the receiver hunts for a start bit from the next tick. A following frame that begins right at the end of the stop bit is therefore received.
- R6: If the stop bit is low, nothing is queued and `frame_err` is set. It stays set until it is cleared.
- R7: After a low stop bit, the receiver accepts no start bit until it has seen the line high on a tick. A line held low after a break produces no further frames and no queued data.
- R8: The queue holds up to 8 bytes in arrival order. A byte is removed when `rd_valid` and `rd_ready` are both high. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low, and `rx_empty` is the inverse of `rd_valid`.
- R9: A good byte that completes while the queue is full is dropped and sets the sticky flag `overrun`. The queued contents are unchanged.
- R10: A one-cycle pulse on `err_clr` clears both `frame_err` and `overrun`.
- R11: The start bit is not checked again at mid-bit. A low glitch on an idle line starts a frame, and if the line stays high after it, the byte 0xFF is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_div | input | 16 | System clocks per oversampling tick (0 treated as 1) |
| rd_valid | output | 1 | Queue holds at least one byte |
| rd_ready | input | 1 | Consumer takes the byte on `rd_data` |
| rd_data | output | 8 | Oldest queued byte |
| rx_empty | output | 1 | Queue is empty |
| frame_err | output | 1 | Sticky: a frame ended with a low stop bit |
| overrun | output | 1 | Sticky: a good byte was lost to a full queue |
| err_clr | input | 1 | One-cycle pulse that clears both sticky flags |

## Verification
A table of bytes is sent, among them alternating, all-zero, all-one and single-bit patterns. Any error in bit order, in the position of the first sample or in the spacing between samples shows up as a wrong byte. Frames sent back to back at a second divider value show whether the receiver re-arms at once and keeps its timing in units of the divider. A long break, a short low glitch and nine unread frames separate the three failure paths from one another. The break must set the frame error, queue nothing and then hold the receiver off until the line is high. The glitch must yield 0xFF. The nine unread frames must keep the first eight bytes and set the overrun flag.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int OSR        = 8;   // ticks per bit period
  localparam int DATA_BITS  = 8;
  localparam int ACC_W      = 32;  // width of the receive shift register
  localparam int FIRST_WAIT = OSR + OSR / 2;  // ticks from start detect to first data sample

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_DATA   = 2'd1,
    ST_STOP   = 2'd2,
    ST_WAITHI = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (div <= 1) || (cnt >= div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= wrap ? '0 : cnt + 1'b1;
      tick <= wrap;
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1 && $stable(div)) |=> !tick);
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_s,
  output logic                 push,
  output logic                 bad_stop,
  output logic [DATA_BITS-1:0] push_byte
);
  localparam int CW = $clog2(FIRST_WAIT);
  localparam int BW = $clog2(DATA_BITS);

  rx_state_t        state;
  logic [CW-1:0]    wait_cnt;
  logic [BW-1:0]    nbits;
  logic [ACC_W-1:0] acc;
  logic             stop_sample;

  assign stop_sample = tick && (state == ST_STOP) && (wait_cnt == '0);
  assign push        = stop_sample && rx_s;
  assign bad_stop    = stop_sample && !rx_s;
  assign push_byte   = acc[ACC_W-1 -: DATA_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      wait_cnt <= '0;
      nbits    <= '0;
      acc      <= '0;
    end else if (tick) begin
      case (state)
        ST_HUNT: begin
          if (!rx_s) begin
            state    <= ST_DATA;
            wait_cnt <= CW'(FIRST_WAIT - 1);
            nbits    <= '0;
          end
        end
        ST_DATA: begin
          if (wait_cnt == '0) begin
            acc      <= {rx_s, acc[ACC_W-1:1]};
            wait_cnt <= CW'(OSR - 1);
            if (nbits == BW'(DATA_BITS - 1)) state <= ST_STOP;
            else                             nbits <= nbits + 1'b1;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_STOP: begin
          if (wait_cnt == '0) state <= rx_s ? ST_HUNT : ST_WAITHI;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        default: begin
          if (rx_s) state <= ST_HUNT;
        end
      endcase
    end
  end

  // R3
  idle_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state) && $stable(acc));
  // R7
  waithi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITHI && !rx_s) |=> state == ST_WAITHI);
  // R5
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> state == ST_HUNT);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          do_wr, do_rd;

  assign full     = (count == (AW+1)'(DEPTH));
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rptr];
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import serial_rx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic [DIV_W-1:0] baud_div,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rx_empty,
  output logic             frame_err,
  output logic             overrun,
  input  logic             err_clr
);
  logic tick, rx_s, push, bad_stop, full;
  logic [DATA_BITS-1:0] push_byte;

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick));

  rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s));

  rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .push(push), .bad_stop(bad_stop), .push_byte(push_byte));

  rx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_BITS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_byte),
    .full(full), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data));

  assign rx_empty = !rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      frame_err <= bad_stop || (frame_err && !err_clr);
      overrun   <= (push && full) || (overrun && !err_clr);
    end
  end

  // R10
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !bad_stop && !push) |=> !frame_err && !overrun);
  // R6
  bad_frame_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stop |=> frame_err && $stable(rd_valid || !rd_ready));
endmodule

// File: tb/serial_rx_top_test.sv
`timescale 1ns/1ps
module serial_rx_top_test;
  logic clk = 0, rst_n = 0, rx_line = 1, rd_ready = 0, err_clr = 0;
  logic [15:0] baud_div = 16'd4;
  logic rd_valid, rx_empty, frame_err, overrun;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  int bitclk = 32;

  always #2 clk = ~clk;

  serial_rx_top uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_div(baud_div),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rx_empty(rx_empty), .frame_err(frame_err), .overrun(overrun),
    .err_clr(err_clr));

  localparam logic [7:0] VEC [8] = '{8'h55, 8'h00, 8'hFF, 8'hA5,
                                     8'h01, 8'h80, 8'h3C, 8'hC3};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b);
    hold(1'b0, bitclk);
    for (int i = 0; i < 8; i++) hold(b[i], bitclk);
    hold(1'b1, bitclk);
  endtask

  task automatic pop();
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", rd_valid, 0);
    check("R1 empty", rx_empty, 1);
    check("R1 flags", {frame_err, overrun}, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);

    // R3 R4 table of bytes
    for (int k = 0; k < 8; k++) begin
      send(VEC[k]);
      repeat (4) @(negedge clk);
      check("R3 valid", rd_valid, 1);
      check("R4 data", rd_data, VEC[k]);
      pop();
      check("R8 empty after pop", rx_empty, 1);
    end

    // R2 R5 back-to-back at another divider
    baud_div = 16'd2; bitclk = 16;
    repeat (40) @(negedge clk);
    send(8'h96); send(8'h69); send(8'h0F);
    repeat (4) @(negedge clk);
    check("R2 first", rd_data, 8'h96);
    // R8 stable while stalled
    repeat (5) @(negedge clk);
    check("R8 stall hold", rd_data, 8'h96);
    pop();
    check("R5 second", rd_data, 8'h69);
    pop();
    check("R5 third", rd_data, 8'h0F);
    pop();
    check("R5 drained", rd_valid, 0);
    check("R5 no err", frame_err, 0);
    baud_div = 16'd4; bitclk = 32;
    repeat (40) @(negedge clk);

    // R6 R7 break then line held low
    hold(1'b0, bitclk * 10);
    check("R6 frame_err", frame_err, 1);
    check("R6 nothing queued", rx_empty, 1);
    hold(1'b0, bitclk * 12);
    check("R7 still empty", rx_empty, 1);
    hold(1'b1, bitclk);
    send(8'h5A);
    repeat (4) @(negedge clk);
    check("R7 recovered byte", rd_data, 8'h5A);
    pop();
    check("R7 one byte only", rx_empty, 1);

    // R10 clear
    err_clr = 1; @(negedge clk); err_clr = 0;
    @(negedge clk);
    check("R10 frame_err cleared", frame_err, 0);

    // R11 glitch
    hold(1'b0, 6);
    hold(1'b1, bitclk * 11);
    check("R11 glitch byte", rd_data, 8'hFF);
    check("R11 glitch valid", rd_valid, 1);
    pop();

    // R9 overrun with nine unread frames
    for (int k = 0; k < 9; k++) send(8'h10 + 8'(k));
    repeat (4) @(negedge clk);
    check("R9 overrun", overrun, 1);
    for (int k = 0; k < 8; k++) begin
      check("R9 kept order", rd_data, 8'h10 + 8'(k));
      pop();
    end
    check("R9 ninth dropped", rd_valid, 0);
    err_clr = 1; @(negedge clk); err_clr = 0;
    @(negedge clk);
    check("R10 overrun cleared", overrun, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule